// File: doc/BRIEF.md
# I2C Slave Command Frame Checker

This block sits between a bit-level I2C slave core and a register file. The core delivers one event at a time: a received byte, a start, a repeated start or a stop. The checker parses each command frame it sees. A frame opens with the device address and a write bit, and a second copy of the address with a zero in its top bit follows it. Next come a command ID and the data bytes that the ID calls for. A CRC-8 byte closes the frame when CRC protection is switched on. A frame that passes every check is released to the register file as a one-cycle command pulse, carrying the ID, the byte count and the buffered data bytes. A frame that fails any check is dropped whole, and a sticky error flag is set until software clears it by reading.

Read access works in two steps. A read command frame (address, repeated address, ID, optional CRC) is accepted at the repeated start that ends it. The master then sends the address with the read bit, and the slave returns its data. The checker keeps a running CRC over every byte since the last start or repeated start. This covers the received address byte and every byte the slave transmits, reported through a transmit strobe, so the register file can append the CRC after its data.

The input is a strobe-only stream with no back-pressure. At 400 kb/s a byte arrives at most every 22.5 µs, and the checker takes every event in the cycle it is offered, so no ready signal is needed. Received bytes and transmitted bytes never share a cycle.

Top module: `ledfrm_check`

## Requirements
- R1: Events are coded on ev_kind as 0 byte, 1 start, 2 repeated start, 3 stop. A frame is handled only if the first byte after a start or repeated start equals {2'b11, addr_lo, 1'b0}. Any other first byte causes no command and no error.
- R2: The second byte must equal {1'b0, 2'b11, addr_lo}. Any other value drops the frame and sets err_flag.
- R3: Known IDs and their data byte counts. Writes: 0x00→2, 0x01→1, 0x02→3, 0x03→12, 0x04→5, 0x20→5, 0x21→5. Reads: 0x08, 0x09, 0x0A, 0x28, each with 0 data bytes. Any other ID drops the frame and sets err_flag.
- R4: A write frame is accepted at its stop event when it is well formed. cmd_valid is high for one cycle, in the cycle after the stop event, with cmd_rd=0, cmd_id and cmd_len. Data byte i sits on cmd_data[8i+7:8i].
- R5: A read command is accepted at the repeated start that ends it, if it carries exactly its 0 data bytes (plus the CRC byte when CRC is on). cmd_valid is high for one cycle, in the next cycle, with cmd_rd=1.
- R6: The CRC-8 uses polynomial 0x2F (x^8+x^5+x^3+x^2+x+1), starts from 0x00, takes bits MSB first, and covers every byte from the first address byte onward. With crc_en=1 the last byte must equal the CRC of all the bytes before it. Otherwise the frame is dropped and err_flag is set.
- R7: With crc_en=0 no CRC byte is expected. One extra byte is a byte-count error: the frame is dropped and err_flag is set.
- R8: crc_out is the CRC of all received and transmitted bytes since the last start or repeated start. It reads 0x00 right after either event and is the byte to append after read data.
- R9: A rejected frame never raises cmd_valid. err_flag rises in the cycle after the event that ends the rejected frame. A frame cut off by a start, repeated start or stop before its body is complete is also rejected.
- R10: err_flag stays set until err_clr is pulsed, and reads 0 in the cycle after the pulse.
- R11: After reset cmd_valid, err_flag and crc_out are 0.
- R12: A write ID ended by a repeated start, or a read ID ended by a stop, is rejected with err_flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| crc_en | input | 1 | 1 = frames carry a CRC byte |
| addr_lo | input | 5 | Configurable low address bits |
| ev_valid | input | 1 | Event strobe from the bit-level core |
| ev_kind | input | 2 | 0 byte, 1 start, 2 repeated start, 3 stop |
| ev_byte | input | 8 | Received byte when ev_kind is 0 |
| tx_valid | input | 1 | Slave transmitted a byte this cycle |
| tx_byte | input | 8 | Transmitted byte |
| err_clr | input | 1 | Clear error flag (flag was read) |
| cmd_valid | output | 1 | One-cycle accepted command pulse |
| cmd_rd | output | 1 | 1 = read command, 0 = write |
| cmd_id | output | 8 | Command ID |
| cmd_len | output | 4 | Number of data bytes |
| cmd_data | output | MAX_BODY*8 | Buffered data bytes, byte 0 lowest |
| err_flag | output | 1 | Sticky communication error |
| crc_out | output | 8 | Running CRC to append to read data |

## Verification
A reference model in the bench holds each frame as a byte queue and decides acceptance from the stated rules. It is compared with the outputs on every clock. Well-formed writes of short and full-length bodies, with CRC both on and off, show that the byte counts per ID and the data placement are right. Frames that each break exactly one rule separate the error causes from one another: a corrupted CRC, a wrong repeated address, an unknown ID, one extra byte, or the wrong terminator. A frame to a foreign address shows that it is ignored without an error. A read command followed by transmitted bytes shows that the CRC restarts at the repeated start and keeps running over the reply.

// File: rtl/ledfrm_pkg.sv
package ledfrm_pkg;
  localparam logic [7:0] CRC_POLY = 8'h2F;
  localparam int LEN_W = 4;

  typedef enum logic [1:0] {
    EV_BYTE    = 2'd0,
    EV_START   = 2'd1,
    EV_RESTART = 2'd2,
    EV_STOP    = 2'd3
  } ev_e;

  typedef struct packed {
    logic             known;
    logic             is_rd;
    logic [LEN_W-1:0] len;
  } id_info_t;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ b[i]) r = {r[6:0], 1'b0} ^ CRC_POLY;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  function automatic id_info_t decode_id(input logic [7:0] id);
    id_info_t d;
    d = '0;
    case (id)
      8'h00: d = '{known: 1'b1, is_rd: 1'b0, len: 4'd2};
      8'h01: d = '{known: 1'b1, is_rd: 1'b0, len: 4'd1};
      8'h02: d = '{known: 1'b1, is_rd: 1'b0, len: 4'd3};
      8'h03: d = '{known: 1'b1, is_rd: 1'b0, len: 4'd12};
      8'h04: d = '{known: 1'b1, is_rd: 1'b0, len: 4'd5};
      8'h20: d = '{known: 1'b1, is_rd: 1'b0, len: 4'd5};
      8'h21: d = '{known: 1'b1, is_rd: 1'b0, len: 4'd5};
      8'h08, 8'h09, 8'h0A, 8'h28:
             d = '{known: 1'b1, is_rd: 1'b1, len: 4'd0};
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ledfrm_crc.sv
module ledfrm_crc
  import ledfrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       absorb,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  logic [7:0] base;
  assign base = clear ? 8'h00 : crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= 8'h00;
    else if (absorb) crc <= crc8_step(base, din);
    else             crc <= base;
  end

  // R8: a restart with no byte leaves the accumulator at zero
  a_r8_crc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear && !absorb) |-> crc == 8'h00);
endmodule

// File: rtl/ledfrm_buf.sv
module ledfrm_buf #(
  parameter int MAX_BODY = 12,
  parameter int IDX_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [7:0]            din,
  output logic [MAX_BODY*8-1:0] dout
);
  for (genvar g = 0; g < MAX_BODY; g++) begin : g_slot
    logic [7:0] slot;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        slot <= 8'h00;
      else if (we && idx == IDX_W'(g))   slot <= din;
    end
    assign dout[g*8 +: 8] = slot;
  end

  // R4: bytes beyond the buffer are never written
  a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(idx) < MAX_BODY);
endmodule

// File: rtl/ledfrm_parse.sv
module ledfrm_parse
  import ledfrm_pkg::*;
#(
  parameter int MAX_BODY = 12,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_en,
  input  logic [4:0]       addr_lo,
  input  logic             ev_valid,
  input  logic [1:0]       ev_kind,
  input  logic [7:0]       ev_byte,
  input  logic [7:0]       crc_cur,
  input  logic             err_clr,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_idx,
  output logic             crc_clear,
  output logic             cmd_valid,
  output logic             cmd_rd,
  output logic [7:0]       cmd_id,
  output logic [LEN_W-1:0] cmd_len,
  output logic             err_flag
);
  typedef enum logic [2:0] {P_IDLE, P_ADDR1, P_ADDR2, P_ID, P_BODY, P_RDADDR} pst_e;

  pst_e             state;
  logic             bad;
  logic [7:0]       id_r;
  logic [CNT_W-1:0] cnt;

  logic [7:0]       addr_w, addr_r, addr_rep;
  id_info_t         info;
  logic [CNT_W-1:0] exp_cnt;
  logic             is_byte, is_start, is_restart, is_stop;
  logic             mid, body_ok, ok_wr, ok_rd, err_set, accept;

  always_comb begin
    addr_w     = {2'b11, addr_lo, 1'b0};
    addr_r     = {2'b11, addr_lo, 1'b1};
    addr_rep   = {1'b0, 2'b11, addr_lo};
    info       = decode_id(id_r);
    exp_cnt    = CNT_W'(info.len) + CNT_W'(crc_en);
    is_byte    = ev_valid && ev_kind == EV_BYTE;
    is_start   = ev_valid && ev_kind == EV_START;
    is_restart = ev_valid && ev_kind == EV_RESTART;
    is_stop    = ev_valid && ev_kind == EV_STOP;
    mid        = state inside {P_ADDR2, P_ID, P_BODY};
    body_ok    = state == P_BODY && !bad && info.known && cnt == exp_cnt &&
                 (!crc_en || crc_cur == 8'h00);
    ok_wr      = body_ok && !info.is_rd;
    ok_rd      = body_ok && info.is_rd;
    accept     = (is_stop && ok_wr) || (is_restart && ok_rd);
    err_set    = mid && ((is_stop && !ok_wr) || (is_restart && !ok_rd) || is_start);
    crc_clear  = is_start || is_restart;
    buf_we     = is_byte && state == P_BODY && cnt < CNT_W'(MAX_BODY);
    buf_idx    = cnt[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= P_IDLE;
      bad       <= 1'b0;
      id_r      <= 8'h00;
      cnt       <= '0;
      cmd_valid <= 1'b0;
      cmd_rd    <= 1'b0;
      cmd_id    <= 8'h00;
      cmd_len   <= '0;
      err_flag  <= 1'b0;
    end else begin
      cmd_valid <= accept;
      if (accept) begin
        cmd_rd  <= is_restart;
        cmd_id  <= id_r;
        cmd_len <= info.len;
      end
      if (err_set)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;

      if (is_start) begin
        state <= P_ADDR1;
      end else if (is_restart) begin
        state <= ok_rd ? P_RDADDR : P_ADDR1;
      end else if (is_stop) begin
        state <= P_IDLE;
      end else if (is_byte) begin
        case (state)
          P_ADDR1: begin
            bad   <= 1'b0;
            cnt   <= '0;
            state <= (ev_byte == addr_w) ? P_ADDR2 : P_IDLE;
          end
          P_ADDR2: begin
            if (ev_byte != addr_rep) bad <= 1'b1;
            state <= P_ID;
          end
          P_ID: begin
            id_r  <= ev_byte;
            if (!decode_id(ev_byte).known) bad <= 1'b1;
            state <= P_BODY;
          end
          P_BODY: if (cnt != '1) cnt <= cnt + CNT_W'(1);
          P_RDADDR: state <= P_IDLE;
          default: state <= P_IDLE;
        endcase
      end
    end
  end

  // R4: a write command only follows a stop event
  a_r4_wr_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_rd |-> $past(is_stop));
  // R5: a read command only follows a repeated start
  a_r5_rd_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_rd |-> $past(is_restart));
  // R9: a rejected frame never produces a command
  a_r9_err_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !cmd_valid);
  // R10: a clear with no new error empties the flag
  a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_clr && !err_set) |-> !err_flag);
endmodule

// File: rtl/ledfrm_check.sv
module ledfrm_check
  import ledfrm_pkg::*;
#(
  parameter int MAX_BODY = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  crc_en,
  input  logic [4:0]            addr_lo,
  input  logic                  ev_valid,
  input  logic [1:0]            ev_kind,
  input  logic [7:0]            ev_byte,
  input  logic                  tx_valid,
  input  logic [7:0]            tx_byte,
  input  logic                  err_clr,
  output logic                  cmd_valid,
  output logic                  cmd_rd,
  output logic [7:0]            cmd_id,
  output logic [3:0]            cmd_len,
  output logic [MAX_BODY*8-1:0] cmd_data,
  output logic                  err_flag,
  output logic [7:0]            crc_out
);
  localparam int IDX_W = $clog2(MAX_BODY);
  localparam int CNT_W = $clog2(MAX_BODY + 2) + 1;

  logic             rx_byte;
  logic             absorb;
  logic [7:0]       crc_din;
  logic             crc_clear;
  logic             buf_we;
  logic [IDX_W-1:0] buf_idx;

  assign rx_byte = ev_valid && ev_kind == EV_BYTE;
  assign absorb  = rx_byte || tx_valid;
  assign crc_din = rx_byte ? ev_byte : tx_byte;

  ledfrm_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clear), .absorb(absorb),
    .din(crc_din), .crc(crc_out)
  );

  ledfrm_parse #(.MAX_BODY(MAX_BODY), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .addr_lo(addr_lo),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .crc_cur(crc_out), .err_clr(err_clr), .buf_we(buf_we), .buf_idx(buf_idx),
    .crc_clear(crc_clear), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_id(cmd_id), .cmd_len(cmd_len), .err_flag(err_flag)
  );

  ledfrm_buf #(.MAX_BODY(MAX_BODY), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .idx(buf_idx), .din(ev_byte),
    .dout(cmd_data)
  );

  // R8: received and transmitted bytes never share a cycle
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_byte && tx_valid));
endmodule

// File: tb/ledfrm_check_test.sv
module ledfrm_check_test;
  typedef logic [7:0] bq_t[$];

  logic        clk = 0, rst_n = 0, crc_en = 0, ev_valid = 0, tx_valid = 0, err_clr = 0;
  logic [4:0]  addr_lo = 5'h0A;
  logic [1:0]  ev_kind = 0;
  logic [7:0]  ev_byte = 0, tx_byte = 0;
  logic        cmd_valid, cmd_rd, err_flag;
  logic [7:0]  cmd_id, crc_out;
  logic [3:0]  cmd_len;
  logic [95:0] cmd_data;

  ledfrm_check uut (.*);

  always #10 clk = ~clk;

  int   tests = 0, fails = 0;
  bit   run = 0, done = 0;
  bq_t  q, seg;
  bit   e_cmd = 0, e_rd = 0, e_err = 0;
  logic [7:0] e_id = 0, e_crc = 0;
  int   e_len = 0;
  logic [7:0] e_data [12];

  function automatic logic [7:0] aw(); return {2'b11, addr_lo, 1'b0}; endfunction
  function automatic logic [7:0] ar(); return {2'b11, addr_lo, 1'b1}; endfunction
  function automatic logic [7:0] a2(); return {1'b0, 2'b11, addr_lo}; endfunction

  function automatic logic [7:0] qcrc(input bq_t b);
    logic [7:0] c = 8'h00;
    foreach (b[k]) begin
      for (int j = 7; j >= 0; j--) begin
        bit fb = c[7] ^ b[k][j];
        c = c << 1;
        if (fb) c = c ^ 8'h2F;
      end
    end
    return c;
  endfunction

  task automatic lookup(input logic [7:0] id, output bit kn, output bit rd, output int n);
    kn = 1; rd = 0; n = 0;
    case (id)
      8'h00: n = 2;  8'h01: n = 1;  8'h02: n = 3;  8'h03: n = 12;
      8'h04: n = 5;  8'h20: n = 5;  8'h21: n = 5;
      8'h08, 8'h09, 8'h0A, 8'h28: rd = 1;
      default: kn = 0;
    endcase
  endtask

  task automatic judge(input bit rd);
    bit kn, ird, ok;
    int n;
    ok = 0;
    if (q.size() >= 3) begin
      lookup(q[2], kn, ird, n);
      ok = q[1] == a2() && kn && ird == rd && q.size() - 3 == n + int'(crc_en) &&
           (!crc_en || qcrc(q) == 8'h00);
      if (ok) begin
        e_cmd = 1; e_rd = rd; e_id = q[2]; e_len = n;
        for (int i = 0; i < n; i++) e_data[i] = q[3 + i];
      end
    end
    if (!ok) e_err = 1;
  endtask

  task automatic model(input logic [1:0] k, input logic [7:0] b);
    bit ours;
    ours = q.size() > 0 && q[0] == aw();
    case (k)
      2'd0: begin q.push_back(b); seg.push_back(b); end
      2'd1: begin if (ours) e_err = 1; q.delete(); seg.delete(); end
      2'd2: begin if (ours) judge(1); q.delete(); seg.delete(); end
      default: begin if (ours) judge(0); q.delete(); end
    endcase
    e_crc = qcrc(seg);
  endtask

  task automatic ev(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1; ev_kind = k; ev_byte = b;
    model(k, b);
    @(negedge clk);
    ev_valid = 0; e_cmd = 0;
  endtask

  task automatic tx(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1; tx_byte = b;
    seg.push_back(b); e_crc = qcrc(seg);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic clr();
    @(negedge clk);
    err_clr = 1; e_err = 0;
    @(negedge clk);
    err_clr = 0;
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // send start + bytes, optionally appending a CRC (good or flipped)
  task automatic frame(input bq_t f, input bit add_crc, input bit crc_bad);
    bq_t g = f;
    if (add_crc) g.push_back(qcrc(f) ^ (crc_bad ? 8'h01 : 8'h00));
    ev(2'd1, 0);
    foreach (g[i]) ev(2'd0, g[i]);
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk); #5;
    if (run && !done) begin
      chk(cmd_valid == e_cmd, "R4 cmd_valid", cmd_valid, e_cmd);
      chk(err_flag == e_err, "R9 err_flag", err_flag, e_err);
      chk(crc_out == e_crc, "R8 crc_out", crc_out, e_crc);
      if (e_cmd) begin
        chk(cmd_rd == e_rd, "R5 cmd_rd", cmd_rd, e_rd);
        chk(cmd_id == e_id, "R3 cmd_id", cmd_id, e_id);
        chk(int'(cmd_len) == e_len, "R3 cmd_len", cmd_len, e_len);
        for (int i = 0; i < e_len; i++)
          chk(cmd_data[8*i +: 8] == e_data[i], "R4 cmd_data", cmd_data[8*i +: 8], e_data[i]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bq_t f;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    // R11 reset state
    chk(!cmd_valid && !err_flag && crc_out == 0, "R11 reset", {cmd_valid, err_flag, crc_out}, 0);
    run = 1;

    // R4 R3: short write, CRC off
    frame('{aw(), a2(), 8'h00, 8'h5A, 8'hC3}, 0, 0); ev(2'd3, 0);
    // R3 R4: full twelve-byte write
    f = '{aw(), a2(), 8'h03};
    for (int i = 0; i < 12; i++) f.push_back(8'(8'h10 + 8'(i * 7)));
    frame(f, 0, 0); ev(2'd3, 0);
    // R7: extra byte with CRC off
    frame('{aw(), a2(), 8'h01, 8'h11, 8'h22}, 0, 0); ev(2'd3, 0);
    chk(err_flag == 1, "R7 extra byte", err_flag, 1);
    clr();
    chk(err_flag == 0, "R10 cleared", err_flag, 0);
    // R1: foreign address ignored
    frame('{8'hC2, 8'h62, 8'h01, 8'h33}, 0, 0); ev(2'd3, 0);
    chk(err_flag == 0, "R1 foreign", err_flag, 0);

    crc_en = 1;
    // R6: good CRC write
    frame('{aw(), a2(), 8'h04, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, 1, 0); ev(2'd3, 0);
    // R6: corrupted CRC
    frame('{aw(), a2(), 8'h01, 8'h7F}, 1, 1); ev(2'd3, 0);
    chk(err_flag == 1, "R6 bad crc", err_flag, 1);
    clr();
    // R2: wrong repeated address
    frame('{aw(), a2() | 8'h80, 8'h01, 8'h7F}, 1, 0); ev(2'd3, 0);
    chk(err_flag == 1, "R2 repeat addr", err_flag, 1);
    clr();
    // R3: unknown ID
    frame('{aw(), a2(), 8'h05, 8'h7F}, 1, 0); ev(2'd3, 0);
    chk(err_flag == 1, "R3 unknown id", err_flag, 1);
    clr();
    // R5 R8: read command then reply with CRC
    frame('{aw(), a2(), 8'h09}, 1, 0); ev(2'd2, 0);
    ev(2'd0, ar()); tx(8'h12); tx(8'hA4);
    chk(crc_out == qcrc('{ar(), 8'h12, 8'hA4}), "R8 reply crc", crc_out, qcrc('{ar(), 8'h12, 8'hA4}));
    ev(2'd3, 0);
    // R12: read ID ended by stop
    frame('{aw(), a2(), 8'h28}, 1, 0); ev(2'd3, 0);
    chk(err_flag == 1, "R12 read by stop", err_flag, 1);
    clr();
    // R12: write ID ended by repeated start
    frame('{aw(), a2(), 8'h01, 8'h44}, 1, 0); ev(2'd2, 0);
    chk(err_flag == 1, "R12 write by restart", err_flag, 1);
    ev(2'd3, 0);
    clr();
    // R9: frame cut short by a new start
    frame('{aw(), a2()}, 0, 0); ev(2'd1, 0);
    chk(err_flag == 1, "R9 truncated", err_flag, 1);
    ev(2'd3, 0);
    clr();

    crc_en = 0;
    // R5: read command, CRC off
    frame('{aw(), a2(), 8'h0A}, 0, 0); ev(2'd2, 0);
    ev(2'd0, ar()); tx(8'h3C); ev(2'd3, 0);
    // R4: another write, CRC off, different ID
    frame('{aw(), a2(), 8'h02, 8'hFF, 8'h00, 8'h81}, 0, 0); ev(2'd3, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule